// File: doc/BRIEF.md
# Shared Digital I/O Port Controller

This block gives a small 8-bit microcontroller control over sixteen bidirectional digital pins through four byte-wide special-function registers. Every register serves a group of four pins. Its high nibble sets which of those pins are outputs. Its low nibble holds the level that each output pin drives. A read returns the direction nibble together with the sampled level of the four pins. The sampled level is the real pin level, so a pin that is driving can still be read back, for example to count pulses that the pin itself produces.

A single global enable bit sits above the per-pin direction bits. It clears at reset and keeps every output driver off until firmware sets it. This prevents short spurious pulses on the pins while the chip comes out of reset. Pin levels pass through a two-flop synchroniser before software can see them. The pad cells sit outside the block, which exchanges separate input, output and output-enable vectors with them.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all direction and data latches and the global enable are 0, pin_oe and pin_out are all 0, and a read of any port returns 0 in bits 7:4.
- R2: The four ports decode at register addresses 0x80 (pins 3:0), 0x90 (pins 7:4), 0xA0 (pins 11:8) and 0xB0 (pins 15:12). sfr_hit is 1 exactly when sfr_addr equals one of these four addresses.
- R3: A write (sfr_wr = 1) to a decoded address loads bits 7:4 into that port's direction latch and bits 3:0 into its data latch at the next rising clock edge. A write to any other address changes no latch.
- R4: A pin's output enable is 1 only when its direction bit is 1 and the global enable is 1. While the global enable is 0, pin_oe is all 0.
- R5: pin_out carries each pin's data latch bit when that pin's output enable is 1, and 0 otherwise.
- R6: A read of a decoded port returns the direction nibble in bits 7:4 and the synchronised pin levels in bits 3:0. This holds for pins that are driving as well.
- R7: A change on pin_in appears in read data after exactly two rising clock edges.
- R8: en_wr = 1 loads en_wdata into the global enable at the next edge. Clearing it stops all drive but leaves the direction and data latches unchanged, so setting it again restores the earlier drive.
- R9: When sfr_hit is 0, sfr_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data: direction in 7:4, data in 3:0 |
| sfr_rdata | output | 8 | Read data: direction in 7:4, pin levels in 3:0 |
| sfr_hit | output | 1 | Address decodes to one of the four ports |
| en_wr | input | 1 | Write strobe for the global enable |
| en_wdata | input | 1 | New global enable value |
| pin_in | input | 16 | Levels arriving from the pads |
| pin_out | output | 16 | Levels driven to the pads |
| pin_oe | output | 16 | Per-pin output-driver enable |

## Verification
A port register write and a global enable write can land on the same clock edge. The first driven cycle then depends on both latches being updated together. The bench issues both strobes in one cycle and expects the exact driven pattern on the very next cycle, with no cycle of partial drive. A second collision is a read of a port whose pins are driving while their levels are still moving through the synchroniser. The bench feeds driven levels back into pin_in, as a pad would, and compares read data on every cycle against a reference model that has its own two-deep sample history.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register address of port number idx.
  function automatic logic [7:0] port_addr(input logic [7:0] base,
                                           input logic [7:0] stride,
                                           input int unsigned idx);
    int unsigned a;
    a = int'(base) + int'(stride) * idx;
    return a[7:0];
  endfunction

  // Drive mask: a pin drives only if it is an output and the port is enabled.
  function automatic logic [3:0] drive_mask(input logic [3:0] dir,
                                            input logic en);
    return en ? dir : 4'b0000;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

  // Latency check, counted from reset so no pre-reset history is used.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  if (STAGES == 2) begin : g_lat_chk
    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_port_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_sel,
  input  logic [PINS-1:0] wr_dir,
  input  logic [PINS-1:0] wr_data,
  input  logic            port_en,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] data_q,
  output logic [PINS-1:0] oe,
  output logic [PINS-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_sel) begin
      dir_q  <= wr_dir;
      data_q <= wr_data;
    end
  end

  if (PINS == 4) begin : g_mask_fn
    assign oe = drive_mask(dir_q, port_en);
  end else begin : g_mask_gen
    assign oe = port_en ? dir_q : '0;
  end

  assign dout = data_q & oe;

  assert_write_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (dir_q == $past(wr_dir)) && (data_q == $past(wr_data)));

  assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(dir_q) && $stable(data_q));

  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (oe == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int         NUM_PORTS     = 4,
  parameter int         PINS_PER_PORT = 4,
  parameter int         SYNC_STAGES   = 2,
  parameter logic [7:0] BASE_ADDR     = 8'h80,
  parameter logic [7:0] ADDR_STRIDE   = 8'h10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [7:0]                           sfr_addr,
  input  logic                                 sfr_wr,
  input  logic [7:0]                           sfr_wdata,
  output logic [7:0]                           sfr_rdata,
  output logic                                 sfr_hit,
  input  logic                                 en_wr,
  input  logic                                 en_wdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_in,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_out,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_oe
);
  localparam int NPINS = NUM_PORTS * PINS_PER_PORT;
  localparam int N     = PINS_PER_PORT;

  // Named internal events for the checks.
  logic [NUM_PORTS-1:0] port_hit;
  logic [NUM_PORTS-1:0] port_wr;
  logic [NPINS-1:0]     dir_all;
  logic [NPINS-1:0]     data_all;
  logic [NPINS-1:0]     pin_sync;
  logic                 en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_wr) en_q <= en_wdata;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_hit[p] = (sfr_addr == port_addr(BASE_ADDR, ADDR_STRIDE, p));
    assign port_wr[p]  = port_hit[p] & sfr_wr;

    gpio_port_bank #(.PINS(N)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (port_wr[p]),
      .wr_dir  (sfr_wdata[2*N-1:N]),
      .wr_data (sfr_wdata[N-1:0]),
      .port_en (en_q),
      .dir_q   (dir_all[p*N +: N]),
      .data_q  (data_all[p*N +: N]),
      .oe      (pin_oe[p*N +: N]),
      .dout    (pin_out[p*N +: N])
    );
  end

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  assign sfr_hit = |port_hit;

  always_comb begin
    sfr_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_hit[p]) sfr_rdata = {dir_all[p*N +: N], pin_sync[p*N +: N]};
    end
  end

  assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_hit));

  assert_nohit_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_hit |-> (sfr_rdata == 8'h00));

  assert_out_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  assert_enable_keeps_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !sfr_wr) |=> $stable(dir_all) && $stable(data_all));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic        en_wr = 1'b0;
  logic        en_wdata = 1'b0;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic [15:0] ext = 16'hA5C3;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
    .en_wr(en_wr), .en_wdata(en_wdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Pad loopback: a driving pin shows its own level.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  // Reference model.
  bit        m_en;
  bit [15:0] m_dir, m_dat;
  bit [15:0] m_hist [$];
  bit [15:0] m_oe, m_out, m_pin, m_seen;

  always_comb begin
    m_oe  = m_en ? m_dir : 16'h0;
    m_out = m_oe & m_dat;
    m_pin = (m_oe & m_out) | (~m_oe & ext);
    m_seen = (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 16'h0;
  end

  function automatic int port_of(input logic [7:0] a);
    case (a)
      8'h80: return 0;
      8'h90: return 1;
      8'hA0: return 2;
      8'hB0: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    int k;
    k = port_of(a);
    if (k < 0) return 8'h00;
    return {m_dir[4*k +: 4], m_seen[4*k +: 4]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_dir = 0; m_dat = 0;
      m_hist.delete();
      m_hist.push_back(16'h0);
      m_hist.push_back(16'h0);
    end else begin
      int k;
      k = port_of(sfr_addr);
      m_hist.push_back(m_pin);
      if (m_hist.size() > 3) void'(m_hist.pop_front());
      if (sfr_wr && k >= 0) begin
        m_dir[4*k +: 4] = sfr_wdata[7:4];
        m_dat[4*k +: 4] = sfr_wdata[3:0];
      end
      if (en_wr) m_en = en_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  bit model_on = 0;
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk("R4 model oe", 32'(pin_oe), 32'(m_oe));
      chk("R5 model out", 32'(pin_out), 32'(m_out));
      chk("R6 model rdata", 32'(sfr_rdata), 32'(m_read(sfr_addr)));
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    tick();
    sfr_wr = 1'b0;
  endtask

  task automatic wr_en(input logic v);
    en_wr = 1'b1; en_wdata = v;
    tick();
    en_wr = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    model_on = 1;
    sfr_addr = 8'h80;
    tick(); tick(); tick();

    // R1: reset state
    chk("R1 oe after reset", 32'(pin_oe), 32'h0);
    chk("R1 out after reset", 32'(pin_out), 32'h0);
    chk("R1 rdata 0x80", 32'(sfr_rdata), 32'h03);

    // R4: direction set but global enable still 0
    wr_port(8'h80, 8'hF5);
    chk("R4 no drive while disabled", 32'(pin_oe), 32'h0);
    chk("R3 dir nibble loaded", 32'(sfr_rdata[7:4]), 32'hF);

    // Same-cycle port write and enable write
    sfr_addr = 8'h90; sfr_wdata = 8'h3A; sfr_wr = 1'b1;
    en_wr = 1'b1; en_wdata = 1'b1;
    tick();
    sfr_wr = 1'b0; en_wr = 1'b0;
    chk("R4 oe after joint write", 32'(pin_oe), 32'h003F);
    chk("R5 out after joint write", 32'(pin_out), 32'h0025);

    // R6: driven pins read back through the synchroniser
    sfr_addr = 8'h80;
    tick(); tick();
    chk("R6 read of driving port", 32'(sfr_rdata), 32'hF5);

    // R2 / R9: decode
    sfr_addr = 8'h88; #1;
    chk("R2 hit on 0x88", 32'(sfr_hit), 32'h0);
    chk("R9 rdata on miss", 32'(sfr_rdata), 32'h00);
    sfr_addr = 8'hB0; #1;
    chk("R2 hit on 0xB0", 32'(sfr_hit), 32'h1);

    // R3: write to an undecoded address is ignored
    wr_port(8'h88, 8'hFF);
    chk("R3 oe after stray write", 32'(pin_oe), 32'h003F);
    sfr_addr = 8'h80; #1;
    chk("R3 port0 after stray write", 32'(sfr_rdata), 32'hF5);
    sfr_addr = 8'hB0; #1;
    chk("R3 port3 after stray write", 32'(sfr_rdata[7:4]), 32'h0);

    // R7: two-edge input latency on port 3 (all inputs)
    chk("R7 before change", 32'(sfr_rdata[3:0]), 32'hA);
    ext[15:12] = 4'h5;
    tick();
    chk("R7 after one edge", 32'(sfr_rdata[3:0]), 32'hA);
    tick();
    chk("R7 after two edges", 32'(sfr_rdata[3:0]), 32'h5);

    // R8: clearing enable keeps latches
    wr_en(1'b0);
    chk("R8 oe cleared", 32'(pin_oe), 32'h0);
    sfr_addr = 8'h80; #1;
    chk("R8 dir kept", 32'(sfr_rdata[7:4]), 32'hF);
    wr_en(1'b1);
    chk("R8 drive restored", 32'(pin_oe), 32'h003F);
    chk("R8 out restored", 32'(pin_out), 32'h0025);

    // Mixed traffic under the per-cycle model comparison
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      ext = 16'($urandom);
      sfr_addr = (r < 8) ? {2'b10, 2'($urandom_range(0, 3)), 4'h0} : 8'($urandom);
      sfr_wdata = 8'($urandom);
      sfr_wr = ($urandom_range(0, 2) == 0);
      en_wr = ($urandom_range(0, 5) == 0);
      en_wdata = ($urandom_range(0, 3) != 0);
      tick();
    end
    sfr_wr = 1'b0; en_wr = 1'b0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule